// File: doc/BRIEF.md
# Framed Test Pattern Generator

The block emits a serial test pattern one bit per clock, most significant bit of each byte first. The pattern is organised as frames, each frame as a programmable number of lines, and each line as a programmable number of bytes. The leading bytes of every line form an overhead region whose content comes from a small programmable byte memory. The remaining bytes form the payload, drawn from one of three sources: the same byte memory, a pseudo-random sequence, or a fixed-level run of bits followed by pseudo-random data. A flag output marks each overhead bit, and a start-of-frame marker flags the first bit of every frame.

Two memory banks, A and B, hold alternative patterns. With alternation enabled, an external select input picks the bank, and a change takes effect only at the next frame boundary so that no frame mixes banks. The data output can be inverted as a whole. Streaming advances only while the enable input is high and holds position while it is low, so a consumer can pause the stream without losing its place.

Top module: `frame_pattern_gen`

## Requirements
- R1: While `en_i` is high, one bit is produced per clock, bit 7 of each byte first. `valid_o` is high in the cycle after each enabled clock, with that bit on `data_o`. While `en_i` is low, the position holds and `valid_o` is 0.
- R2: Bytes with index below `oh_bytes_i` in every line (at least 4) are overhead. For those bytes `oh_o`=1 and the data is the byte stored at address (byte index mod 64) of the active bank. All other bytes give `oh_o`=0.
- R3: A line has `bytes_i` bytes, a frame has `lines_i` lines (1 to 16), and a pattern has `frames_i` frames, after which it repeats. `sof_o`=1 exactly on bit 0 of byte 0 of line 0 of every frame.
- R4: With `payload_sel_i`=0, each payload bit comes from the byte at address (byte index mod 64) of the active bank.
- R5: With `payload_sel_i`=1, the payload is taken from a 7-stage shift register s with polynomial x^7+x^6+1. The output bit is s[6], and each step sets s to {s[5:0], s[6]^s[5]}. It steps on every enabled clock, overhead included, and is reloaded to all ones for the first bit of each pattern repetition and after reset.
- R6: With `payload_sel_i`=2, the first `run_bits_i` payload bits of each line equal `run_level_i` and the rest follow the R5 sequence. The payload bit index is (byte index - `oh_bytes_i`)*8 + bit position.
- R7: The active bank is A (0) after reset. It is updated only when the last bit of a frame is produced: to A when `alt_en_i`=0, otherwise to A if `alt_sel_i`=1 and B (1) if `alt_sel_i`=0.
- R8: `invert_i`=1 inverts `data_o` and leaves `oh_o` and `sof_o` unchanged.
- R9: A clock with `wr_en_i`=1 stores `wr_data_i` at address `wr_addr_i` of bank `wr_bank_i`.
- R10: During reset, `valid_o`, `data_o`, `oh_o` and `sof_o` are 0 and the position returns to the start of a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance one bit this cycle |
| bytes_i | input | 16 | Bytes per line |
| oh_bytes_i | input | 16 | Overhead bytes per line |
| lines_i | input | 5 | Lines per frame |
| frames_i | input | 13 | Frames per pattern |
| payload_sel_i | input | 2 | 0 memory, 1 pseudo-random, 2 run then pseudo-random |
| run_bits_i | input | 19 | Run length in payload bits |
| run_level_i | input | 1 | Level of the run bits |
| alt_en_i | input | 1 | Enable bank alternation |
| alt_sel_i | input | 1 | 1 selects bank A, 0 bank B |
| invert_i | input | 1 | Invert data output |
| wr_en_i | input | 1 | Memory write strobe |
| wr_bank_i | input | 1 | Write bank (0 A, 1 B) |
| wr_addr_i | input | 6 | Write address |
| wr_data_i | input | 8 | Write byte |
| valid_o | output | 1 | Output bit valid |
| data_o | output | 1 | Serial pattern bit |
| oh_o | output | 1 | Bit belongs to overhead |
| sof_o | output | 1 | First bit of a frame |

## Verification
A frame boundary and a bank change can fall in the same cycle. The bench provokes this by pausing the stream in the middle of a frame, flipping the alternate select, and resuming. The scoreboard expects the rest of that frame from the old bank and the next frame from the new one. A pattern wrap also coincides with the pseudo-random reload and an overhead byte. These are checked together by running several pattern repetitions in pseudo-random mode and comparing every bit, flag and frame marker against an independent model.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    PL_WORD = 2'd0,
    PL_PRBS = 2'd1,
    PL_RUN  = 2'd2
  } payload_e;

  localparam int unsigned BANKS = 2;
endpackage

// File: rtl/fpg_pos_ctr.sv
module fpg_pos_ctr #(
  parameter int unsigned BYTE_W  = 16,
  parameter int unsigned LINE_W  = 5,
  parameter int unsigned FRAME_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [BYTE_W-1:0]  bytes_i,
  input  logic [LINE_W-1:0]  lines_i,
  input  logic [FRAME_W-1:0] frames_i,
  output logic [2:0]         bit_o,
  output logic [BYTE_W-1:0]  byte_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_end_o,
  output logic               pat_end_o
);
  logic [2:0]         bit_q;
  logic [BYTE_W-1:0]  byte_q;
  logic [LINE_W-1:0]  line_q;
  logic [FRAME_W-1:0] frame_q;
  logic last_bit, last_byte, last_line, last_frame;

  assign last_bit   = (bit_q == 3'd7);
  assign last_byte  = (byte_q == bytes_i - BYTE_W'(1));
  assign last_line  = (line_q == lines_i - LINE_W'(1));
  assign last_frame = (frame_q == frames_i - FRAME_W'(1));

  assign frame_end_o = last_bit && last_byte && last_line;
  assign pat_end_o   = frame_end_o && last_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '0;
      byte_q  <= '0;
      line_q  <= '0;
      frame_q <= '0;
    end else if (en_i) begin
      bit_q <= bit_q + 3'd1;
      if (last_bit) begin
        if (!last_byte) begin
          byte_q <= byte_q + BYTE_W'(1);
        end else begin
          byte_q <= '0;
          if (!last_line) begin
            line_q <= line_q + LINE_W'(1);
          end else begin
            line_q  <= '0;
            frame_q <= last_frame ? '0 : frame_q + FRAME_W'(1);
          end
        end
      end
    end
  end

  assign bit_o   = bit_q;
  assign byte_o  = byte_q;
  assign line_o  = line_q;
  assign frame_o = frame_q;

  // R1
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> bit_q == $past(bit_q) + 3'd1);

  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({bit_q, byte_q, line_q, frame_q}));

  // R3
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (line_q < lines_i) && (byte_q < bytes_i));
endmodule

// File: rtl/fpg_prbs.sv
module fpg_prbs #(
  parameter int unsigned WIDTH = 7,
  parameter int unsigned TAP   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic reseed_i,
  output logic bit_o
);
  logic [WIDTH-1:0] lfsr_q;
  logic             fb;

  assign fb    = lfsr_q[WIDTH-1] ^ lfsr_q[TAP-1];
  assign bit_o = lfsr_q[WIDTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lfsr_q <= '1;
    else if (reseed_i) lfsr_q <= '1;
    else if (adv_i)    lfsr_q <= {lfsr_q[WIDTH-2:0], fb};
  end

  // R5
  prbs_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/fpg_word_mem.sv
module fpg_word_mem
  import fpg_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_bank_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] rd_bank_data [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [7:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == 1'(b))) mem_q[wr_addr_i] <= wr_data_i;
    end
    assign rd_bank_data[b] = mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_bank_data[rd_bank_i];
endmodule

// File: rtl/frame_pattern_gen.sv
module frame_pattern_gen
  import fpg_pkg::*;
#(
  parameter int unsigned BYTE_W    = 16,
  parameter int unsigned LINE_W    = 5,
  parameter int unsigned FRAME_W   = 13,
  parameter int unsigned MEM_DEPTH = 64,
  parameter int unsigned PRBS_W    = 7,
  parameter int unsigned PRBS_TAP  = 6,
  localparam int unsigned ADDR_W   = $clog2(MEM_DEPTH),
  localparam int unsigned RUN_W    = BYTE_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [BYTE_W-1:0]  bytes_i,
  input  logic [BYTE_W-1:0]  oh_bytes_i,
  input  logic [LINE_W-1:0]  lines_i,
  input  logic [FRAME_W-1:0] frames_i,
  input  logic [1:0]         payload_sel_i,
  input  logic [RUN_W-1:0]   run_bits_i,
  input  logic               run_level_i,
  input  logic               alt_en_i,
  input  logic               alt_sel_i,
  input  logic               invert_i,
  input  logic               wr_en_i,
  input  logic               wr_bank_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  output logic               valid_o,
  output logic               data_o,
  output logic               oh_o,
  output logic               sof_o
);
  logic [2:0]         bit_idx;
  logic [BYTE_W-1:0]  byte_idx;
  logic [LINE_W-1:0]  line_idx;
  logic [FRAME_W-1:0] frame_idx;
  logic               frame_end, pat_end;
  logic               bank_q;
  logic               prbs_bit;
  logic [7:0]         rd_byte;
  logic               oh_now, mem_bit, pat_bit, sof_now;
  logic [RUN_W-1:0]   pay_idx;
  payload_e           sel;

  fpg_pos_ctr #(.BYTE_W(BYTE_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_pos (
    .clk_i, .rst_ni, .en_i,
    .bytes_i, .lines_i, .frames_i,
    .bit_o(bit_idx), .byte_o(byte_idx), .line_o(line_idx), .frame_o(frame_idx),
    .frame_end_o(frame_end), .pat_end_o(pat_end)
  );

  fpg_prbs #(.WIDTH(PRBS_W), .TAP(PRBS_TAP)) u_prbs (
    .clk_i, .rst_ni,
    .adv_i(en_i), .reseed_i(en_i && pat_end),
    .bit_o(prbs_bit)
  );

  fpg_word_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk_i, .wr_en_i, .wr_bank_i, .wr_addr_i, .wr_data_i,
    .rd_bank_i(bank_q), .rd_addr_i(byte_idx[ADDR_W-1:0]),
    .rd_data_o(rd_byte)
  );

  // bank swaps only between frames so no frame mixes A and B
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bank_q <= 1'b0;
    else if (en_i && frame_end) bank_q <= alt_en_i ? ~alt_sel_i : 1'b0;
  end

  assign sel     = payload_e'(payload_sel_i);
  assign oh_now  = byte_idx < oh_bytes_i;
  assign mem_bit = rd_byte[3'd7 - bit_idx];
  assign pay_idx = {byte_idx - oh_bytes_i, bit_idx};
  assign sof_now = (bit_idx == 3'd0) && (byte_idx == '0) && (line_idx == '0);

  always_comb begin
    if (oh_now) pat_bit = mem_bit;
    else begin
      unique case (sel)
        PL_WORD: pat_bit = mem_bit;
        PL_RUN:  pat_bit = (pay_idx < run_bits_i) ? run_level_i : prbs_bit;
        default: pat_bit = prbs_bit;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
      oh_o    <= 1'b0;
      sof_o   <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        data_o <= pat_bit ^ invert_i;
        oh_o   <= oh_now;
        sof_o  <= sof_now;
      end
    end
  end

  // R7
  bank_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_q) |-> $past(en_i && frame_end));

  // R2
  oh_first_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && byte_idx == '0) |=> oh_o);

  // R3
  sof_first_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && frame_end) |=> !sof_o);
endmodule

// File: tb/frame_pattern_gen_tb_top.sv
module frame_pattern_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [15:0] bytes_c = 16'd12, oh_c = 16'd4;
  logic [4:0]  lines_c = 5'd2;
  logic [12:0] frames_c = 13'd2;
  logic [1:0]  sel_c = 2'd0;
  logic [18:0] run_c = '0;
  logic run_lvl = 1'b0, alt_en = 1'b0, alt_sel = 1'b0, inv = 1'b0;
  logic wr_en = 1'b0, wr_bank = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic valid, data, oh, sof;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  logic [2:0] q_bits [$];
  string      q_tag  [$];

  logic [7:0] mem_m [2][64];
  int m_bit, m_byte, m_line, m_frame, m_bank;
  logic [6:0] m_lfsr;

  always #2 clk = ~clk;

  frame_pattern_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .bytes_i(bytes_c), .oh_bytes_i(oh_c), .lines_i(lines_c), .frames_i(frames_c),
    .payload_sel_i(sel_c), .run_bits_i(run_c), .run_level_i(run_lvl),
    .alt_en_i(alt_en), .alt_sel_i(alt_sel), .invert_i(inv),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .valid_o(valid), .data_o(data), .oh_o(oh), .sof_o(sof)
  );

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b (data,oh,sof) t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: pop expected items as the design emits them
  always @(negedge clk) begin
    cycles++;
    if (rst_n && valid) begin
      if (q_bits.size() == 0) check("R1 extra bit", {data, oh, sof}, 3'bxxx);
      else check(q_tag.pop_front(), {data, oh, sof}, q_bits.pop_front());
    end
  end

  initial begin
    while (cycles < 100000) @(negedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic mem_write(int bank, int addr, logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = bank[0]; wr_addr = addr[5:0]; wr_data = v;
    mem_m[bank][addr] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_bit = 0; m_byte = 0; m_line = 0; m_frame = 0; m_bank = 0; m_lfsr = 7'h7F;
    @(negedge clk);
    check("R10", {data, oh, sof}, 3'b000);
    check("R10 valid", {2'b00, valid}, 3'b000);
    rst_n = 1'b1;
  endtask

  function automatic logic [2:0] model_step();
    logic ob, mb, b, s;
    int pb;
    logic [7:0] by;
    ob = (m_byte < int'(oh_c));
    by = mem_m[m_bank][m_byte % 64];
    mb = by[7 - m_bit];
    pb = (m_byte - int'(oh_c)) * 8 + m_bit;
    if (ob || sel_c == 2'd0) b = mb;
    else if (sel_c == 2'd2 && pb < int'(run_c)) b = run_lvl;
    else b = m_lfsr[6];
    s = (m_bit == 0 && m_byte == 0 && m_line == 0);
    m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
    if (m_bit == 7) begin
      m_bit = 0;
      if (m_byte == int'(bytes_c) - 1) begin
        m_byte = 0;
        if (m_line == int'(lines_c) - 1) begin
          m_line = 0;
          m_bank = alt_en ? int'(!alt_sel) : 0;
          if (m_frame == int'(frames_c) - 1) begin
            m_frame = 0;
            m_lfsr = 7'h7F;
          end else m_frame++;
        end else m_line++;
      end else m_byte++;
    end else m_bit++;
    return {b ^ inv, ob, s};
  endfunction

  task automatic run_bits(int n);
    for (int i = 0; i < n; i++) begin
      q_bits.push_back(model_step());
      q_tag.push_back(cur_req);
    end
    @(negedge clk);
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
  endtask

  task automatic pause(int n);
    repeat (n) begin
      @(negedge clk);
      check("R1 hold", {2'b00, valid}, 3'b000);
    end
  endtask

  initial begin
    for (int a = 0; a < 64; a++) begin
      mem_m[0][a] = 8'(a * 37 + 5);
      mem_m[1][a] = 8'(a * 91 + 200);
    end
    repeat (2) @(negedge clk);
    do_reset();
    // R9: load both banks through the write port
    for (int a = 0; a < 16; a++) begin
      mem_write(0, a, 8'(a * 37 + 5));
      mem_write(1, a, 8'(a * 91 + 200));
    end

    // R4 / R2 / R3: memory payload, two patterns in odd chunks with pauses
    cur_req = "R4 word payload";
    run_bits(101); pause(3);
    cur_req = "R2 overhead";
    run_bits(283); pause(2);
    cur_req = "R3 framing";
    run_bits(384);

    // R5: pseudo-random payload across three pattern repetitions
    sel_c = 2'd1;
    do_reset();
    cur_req = "R5 prbs";
    run_bits(3 * 384);

    // R6: run then pseudo-random, single-line frames, several run lengths
    sel_c = 2'd2; lines_c = 5'd1; frames_c = 13'd3; run_c = 19'd13; run_lvl = 1'b1;
    do_reset();
    cur_req = "R6 run 13";
    run_bits(300);
    run_c = 19'd0; run_lvl = 1'b0;
    do_reset();
    cur_req = "R6 run 0";
    run_bits(200);
    run_c = 19'd64; run_lvl = 1'b1;
    do_reset();
    cur_req = "R6 run full";
    run_bits(200);

    // R8: inversion
    inv = 1'b1; sel_c = 2'd1; lines_c = 5'd2; frames_c = 13'd2;
    do_reset();
    cur_req = "R8 invert";
    run_bits(400);
    inv = 1'b0;

    // R7: bank switch requested mid-frame, seen only from the next frame
    sel_c = 2'd0; alt_en = 1'b1; alt_sel = 1'b1;
    do_reset();
    cur_req = "R7 bank A";
    run_bits(100); pause(2);
    alt_sel = 1'b0;
    cur_req = "R7 switch to B";
    run_bits(300); pause(2);
    alt_sel = 1'b1;
    cur_req = "R7 back to A";
    run_bits(250);
    alt_en = 1'b0; alt_sel = 1'b0;
    cur_req = "R7 alternation off";
    run_bits(400);

    repeat (4) @(negedge clk);
    check("R1 stream drained", {2'b00, q_bits.size() == 0}, 3'b001);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule